// File: doc/BRIEF.md
# Masked Interrupt Dispatcher with Per-Source Vector Routing

This block sits between interrupt capture logic and a bank of interrupt lines toward a processor. It receives a pending vector and two per-source strobe vectors, one asking for assertion and one for withdrawal. Each strobe event is filtered through a 64-bit mask. Each event services at most one source: the lowest-numbered eligible one. That source's in-service bit is set or cleared, and the output line picked by that source's 8-bit vector byte is driven high or low. Output lines are registered and keep their level until a later dispatch addresses them again.

Software reaches the block through a 32-bit word register window and two byte-wide tables. Writing a mask half is a dispatch event in its own right. Bits that become unmasked run an assertion pass over those bits. Bits that become masked run a withdrawal pass over those bits. The in-service register can be read through the mask as a status word, and software can load it directly. An identification word reports a version and the number of supported sources. An enable word and a polarity word are kept only as storage. A route table is stored alongside the vector table and has no effect on dispatch.

Top module: `irq_vector_dispatch`

## Requirements
- R1: After reset, `irq_o` is all zero. Both mask words read 0xFFFFFFFF. Every vector entry reads 0 and every route entry reads 1. The enable, polarity and status words read 0.
- R2: When `rise_evt_i` is non-zero, the candidates are `rise_evt_i & pend_i & ~mask`. If any candidate exists, the in-service bit of the lowest-indexed candidate is set on that clock edge. On the same edge, `irq_o[vector]` goes high.
- R3: When `fall_evt_i` is non-zero, the candidates are `fall_evt_i & in_service`. If any candidate exists, the in-service bit of the lowest-indexed candidate is cleared on that clock edge. On the same edge, `irq_o[vector]` goes low.
- R4: A single dispatch pass changes at most one in-service bit in each direction. All other candidates are left unchanged.
- R5: A write to mask word 0x008 (sources 31:0) or 0x00C (sources 63:32) runs an assertion pass over the bits that change from 1 to 0. That pass is judged against the new mask.
- R6: A mask write runs a withdrawal pass over the bits that change from 0 to 1.
- R7: Status words 0x018 (low) and 0x01C (high) read `in_service & ~mask`. A write to either word loads that half of the in-service register. Any dispatch in the same cycle applies on top of the loaded value.
- R8: Vector byte i is at 0x100+i and route byte i is at 0x200+i, both carried in `bus_wdata_i[7:0]` and `bus_rdata_o[7:0]`. An index at or above NSRC reads zero, and a write to it is ignored.
- R9: Word 0x000 reads the constant ID_WORD. Word 0x004 reads VERSION in bits 15:0 and NSRC-1 in bits 31:16.
- R10: When a withdrawal and an assertion are requested in the same cycle, the withdrawal is applied first. If both address the same output, that output ends high.
- R11: A source whose vector is NOUT or above changes its in-service bit but drives no output. In a cycle with no dispatch, `irq_o` holds its value.
- R12: Enable words 0x010/0x014 and polarity words 0x020/0x024 read back what was written. Writing them affects neither `irq_o` nor the status words.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| pend_i | input | NSRC | Pending level per source |
| rise_evt_i | input | NSRC | Per-source assertion strobes |
| fall_evt_i | input | NSRC | Per-source withdrawal strobes |
| bus_wr_i | input | 1 | Register write strobe |
| bus_addr_i | input | 12 | Register byte address |
| bus_wdata_i | input | 32 | Register write data |
| bus_rdata_o | output | 32 | Register read data (combinational) |
| irq_o | output | NOUT | Registered interrupt lines |

## Verification
The hardest case to reach is a mask write that triggers dispatch while the in-service register and the output lines are already in mixed states. This is especially so when the lowest changed bit is not a candidate and a higher changed bit is. The bench reaches this by sweeping every low-byte mask value in sequence with all sources pending. Each step therefore starts from the state the previous step left behind. Every pending pattern is also swept under full assertion and withdrawal strobes. Vectors are arranged so that two sources share a line and one source points past the last line.

// File: rtl/irq_vector_dispatch.sv
module irq_vector_dispatch #(
  parameter int          NSRC    = 64,
  parameter int          NOUT    = 64,
  parameter logic [15:0] VERSION = 16'h0001,
  parameter logic [31:0] ID_WORD = 32'h0700_0000
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [NSRC-1:0] pend_i,
  input  logic [NSRC-1:0] rise_evt_i,
  input  logic [NSRC-1:0] fall_evt_i,
  input  logic            bus_wr_i,
  input  logic [11:0]     bus_addr_i,
  input  logic [31:0]     bus_wdata_i,
  output logic [31:0]     bus_rdata_o,
  output logic [NOUT-1:0] irq_o
);
  localparam int IW = (NSRC > 1) ? $clog2(NSRC) : 1;
  localparam int OW = (NOUT > 1) ? $clog2(NOUT) : 1;
  localparam logic [63:0] SRC_ALL = (NSRC >= 64) ? {64{1'b1}} : ((64'd1 << NSRC) - 64'd1);

  logic [63:0] mask_q, en_q, pol_q, svc_q;
  logic [7:0]  vec_q   [NSRC];
  logic [7:0]  route_q [NSRC];
  logic [NOUT-1:0] irq_q, irq_nx;

  wire       in_words = bus_addr_i[11:8] == 4'h0;
  wire [5:0] wsel     = bus_addr_i[7:2];
  wire [7:0] tidx     = bus_addr_i[7:0];
  wire       t_ok     = 32'(tidx) < NSRC;
  wire       vec_wr   = bus_wr_i && bus_addr_i[11:8] == 4'h1 && t_ok;
  wire       rte_wr   = bus_wr_i && bus_addr_i[11:8] == 4'h2 && t_ok;

  logic [9:0] wr_w;
  always_comb
    for (int k = 0; k < 10; k++) wr_w[k] = bus_wr_i && in_words && wsel == 6'(k);

  wire mask_wr = wr_w[2] | wr_w[3];
  wire st_wr   = wr_w[6] | wr_w[7];

  function automatic logic [6:0] lowest(input logic [63:0] v);
    logic [6:0] r;
    r = '0;
    for (int i = 63; i >= 0; i--)
      if (v[i]) r = {1'b1, 6'(i)};
    return r;
  endfunction

  logic [63:0] mask_nx, svc_base, svc_nx;
  always_comb begin
    mask_nx = mask_q;
    if (wr_w[2]) mask_nx[31:0]  = bus_wdata_i;
    if (wr_w[3]) mask_nx[63:32] = bus_wdata_i;
    svc_base = svc_q;
    if (wr_w[6]) svc_base[31:0]  = bus_wdata_i;
    if (wr_w[7]) svc_base[63:32] = bus_wdata_i;
  end

  wire [63:0] unmasked = mask_q & ~mask_nx;
  wire [63:0] newmask  = ~mask_q & mask_nx;
  wire [63:0] dn_cand  = (64'(fall_evt_i) | newmask) & svc_base & SRC_ALL;
  wire [63:0] up_cand  = (64'(rise_evt_i) | unmasked) & 64'(pend_i) & ~mask_nx & SRC_ALL;
  wire [6:0]  dn = lowest(dn_cand);
  wire [6:0]  up = lowest(up_cand);
  wire [7:0]  dn_vec = vec_q[dn[IW-1:0]];
  wire [7:0]  up_vec = vec_q[up[IW-1:0]];

  always_comb begin
    svc_nx = svc_base;
    irq_nx = irq_q;
    if (dn[6]) begin
      svc_nx[dn[5:0]] = 1'b0;
      if (32'(dn_vec) < NOUT) irq_nx[dn_vec[OW-1:0]] = 1'b0;
    end
    if (up[6]) begin
      svc_nx[up[5:0]] = 1'b1;
      if (32'(up_vec) < NOUT) irq_nx[up_vec[OW-1:0]] = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mask_q <= '1;
      en_q   <= '0;
      pol_q  <= '0;
      svc_q  <= '0;
      irq_q  <= '0;
    end else begin
      mask_q <= mask_nx;
      svc_q  <= svc_nx;
      irq_q  <= irq_nx;
      if (wr_w[4]) en_q[31:0]   <= bus_wdata_i;
      if (wr_w[5]) en_q[63:32]  <= bus_wdata_i;
      if (wr_w[8]) pol_q[31:0]  <= bus_wdata_i;
      if (wr_w[9]) pol_q[63:32] <= bus_wdata_i;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < NSRC; i++) begin
        vec_q[i]   <= 8'h00;
        route_q[i] <= 8'h01;
      end
    end else begin
      for (int i = 0; i < NSRC; i++) begin
        if (vec_wr && tidx == 8'(i)) vec_q[i]   <= bus_wdata_i[7:0];
        if (rte_wr && tidx == 8'(i)) route_q[i] <= bus_wdata_i[7:0];
      end
    end
  end

  wire [63:0] status = svc_q & ~mask_q;

  always_comb begin
    bus_rdata_o = '0;
    unique case (bus_addr_i[11:8])
      4'h0: case (wsel)
        6'd0: bus_rdata_o = ID_WORD;
        6'd1: bus_rdata_o = {16'(NSRC - 1), VERSION};
        6'd2: bus_rdata_o = mask_q[31:0];
        6'd3: bus_rdata_o = mask_q[63:32];
        6'd4: bus_rdata_o = en_q[31:0];
        6'd5: bus_rdata_o = en_q[63:32];
        6'd6: bus_rdata_o = status[31:0];
        6'd7: bus_rdata_o = status[63:32];
        6'd8: bus_rdata_o = pol_q[31:0];
        6'd9: bus_rdata_o = pol_q[63:32];
        default: bus_rdata_o = '0;
      endcase
      4'h1: if (t_ok) bus_rdata_o = {24'd0, vec_q[tidx[IW-1:0]]};
      4'h2: if (t_ok) bus_rdata_o = {24'd0, route_q[tidx[IW-1:0]]};
      default: bus_rdata_o = '0;
    endcase
  end

  assign irq_o = irq_q;
endmodule

// File: rtl/irq_vector_dispatch_chk.sv
module irq_vector_dispatch_chk #(
  parameter int NSRC = 64,
  parameter int NOUT = 64
) (
  input logic            clk,
  input logic            rst_n,
  input logic [NSRC-1:0] rise_evt,
  input logic [NSRC-1:0] fall_evt,
  input logic            mask_wr,
  input logic            st_wr,
  input logic [63:0]     svc,
  input logic [NOUT-1:0] irq
);
  // R11
  idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rise_evt == '0 && fall_evt == '0 && !mask_wr) |=> $stable(irq));

  // R4
  one_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !st_wr |=> $countones(svc & ~$past(svc)) <= 1);

  // R2
  no_stray_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!st_wr && rise_evt == '0 && !mask_wr) |=> (svc & ~$past(svc)) == '0);

  // R3
  no_stray_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!st_wr && fall_evt == '0 && !mask_wr) |=> (~svc & $past(svc)) == '0);

  // R10
  line_flip_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $countones(irq ^ $past(irq)) <= 2);
endmodule

bind irq_vector_dispatch irq_vector_dispatch_chk #(.NSRC(NSRC), .NOUT(NOUT)) chk_i (
  .clk(clk), .rst_n(rst_n), .rise_evt(rise_evt_i), .fall_evt(fall_evt_i),
  .mask_wr(mask_wr), .st_wr(st_wr), .svc(svc_q), .irq(irq_o)
);

// File: tb/irq_vector_dispatch_tb_top.sv
`timescale 1ns/1ps
module irq_vector_dispatch_tb_top;
  localparam int NS = 8;
  localparam int NO = 4;
  localparam logic [15:0] VER = 16'h0001;
  localparam logic [31:0] IDW = 32'h0700_0000;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [NS-1:0] pend = '0, rise = '0, fall = '0;
  logic bus_wr = 1'b0;
  logic [11:0] bus_addr = '0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic [NO-1:0] irq;

  always #2 clk = ~clk;

  irq_vector_dispatch #(.NSRC(NS), .NOUT(NO), .VERSION(VER), .ID_WORD(IDW)) dut_i (
    .clk(clk), .rst_n(rst_n), .pend_i(pend), .rise_evt_i(rise), .fall_evt_i(fall),
    .bus_wr_i(bus_wr), .bus_addr_i(bus_addr), .bus_wdata_i(bus_wdata),
    .bus_rdata_o(bus_rdata), .irq_o(irq)
  );

  int n_chk = 0, n_bad = 0;
  bit finished = 0;
  logic [63:0] m_mask = '1, m_isr = '0;
  logic [NO-1:0] m_out = '0;
  logic [7:0] m_vec [NS];

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic rd(input logic [11:0] a, output logic [31:0] d);
    bus_addr = a;
    #0.2;
    d = bus_rdata;
  endtask

  task automatic bwr(input logic [11:0] a, input logic [31:0] d);
    @(negedge clk);
    bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    @(posedge clk); #1;
    bus_wr = 1'b0;
  endtask

  task automatic cyc(input logic [NS-1:0] a, input logic [NS-1:0] d,
                     input logic mw, input logic [31:0] mv,
                     input logic sw, input logic [31:0] sv);
    logic [63:0] nm, av, dv, base;
    bit hit;
    @(negedge clk);
    rise = a; fall = d;
    bus_wr = mw | sw;
    bus_addr = mw ? 12'h008 : 12'h018;
    bus_wdata = mw ? mv : sv;
    nm = m_mask;
    if (mw) nm[31:0] = mv;
    av = 64'(a) | (m_mask & ~nm);
    dv = 64'(d) | (~m_mask & nm);
    base = sw ? {m_isr[63:32], sv} : m_isr;
    hit = 0;
    for (int i = 0; i < NS; i++)
      if (!hit && dv[i] && base[i]) begin
        hit = 1; base[i] = 1'b0;
        if (m_vec[i] < NO) m_out[m_vec[i][1:0]] = 1'b0;
      end
    hit = 0;
    for (int i = 0; i < NS; i++)
      if (!hit && av[i] && pend[i] && !nm[i]) begin
        hit = 1; base[i] = 1'b1;
        if (m_vec[i] < NO) m_out[m_vec[i][1:0]] = 1'b1;
      end
    m_mask = nm; m_isr = base;
    @(posedge clk); #1;
    rise = '0; fall = '0; bus_wr = 1'b0;
  endtask

  task automatic cmp(input string tag);
    logic [31:0] d;
    chk({tag, " irq"}, 32'(irq), 32'(m_out));
    rd(12'h018, d);
    chk({tag, " status"}, d, m_isr[31:0] & ~m_mask[31:0]);
  endtask

  initial begin
    #(4 * 150000);
    if (!finished) begin
      n_bad++; n_chk++;
      $display("FAIL watchdog expired");
      $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
      $finish;
    end
  end

  initial begin
    logic [31:0] d;
    for (int i = 0; i < NS; i++) m_vec[i] = 8'h00;
    #9 rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    chk("R1 irq", 32'(irq), 32'h0);
    rd(12'h008, d); chk("R1 mask lo", d, 32'hFFFF_FFFF);
    rd(12'h00C, d); chk("R1 mask hi", d, 32'hFFFF_FFFF);
    rd(12'h010, d); chk("R1 enable", d, 32'h0);
    rd(12'h020, d); chk("R1 polarity", d, 32'h0);
    rd(12'h018, d); chk("R1 status", d, 32'h0);
    for (int i = 0; i < NS; i++) begin
      rd(12'h100 + 12'(i), d); chk("R1 vector", d, 32'h0);
      rd(12'h200 + 12'(i), d); chk("R1 route", d, 32'h1);
    end
    // R9 identification
    rd(12'h000, d); chk("R9 id lo", d, IDW);
    rd(12'h004, d); chk("R9 id hi", d, {16'(NS - 1), VER});
    // R8 tables
    for (int i = 0; i < NS; i++) begin
      m_vec[i] = 8'((i * 3) % 5);
      bwr(12'h100 + 12'(i), {24'hABCDEF, m_vec[i]});
    end
    for (int i = 0; i < NS; i++) begin
      rd(12'h100 + 12'(i), d); chk("R8 vector readback", d, 32'(m_vec[i]));
    end
    bwr(12'h202, 32'h5A);
    rd(12'h202, d); chk("R8 route readback", d, 32'h5A);
    bwr(12'h108, 32'h77); bwr(12'h1C8, 32'h66); bwr(12'h209, 32'h55);
    rd(12'h108, d); chk("R8 vector oor", d, 32'h0);
    rd(12'h1C8, d); chk("R8 vector oor high", d, 32'h0);
    rd(12'h209, d); chk("R8 route oor", d, 32'h0);
    rd(12'h100, d); chk("R8 vector 0 intact", d, 32'(m_vec[0]));
    // R12 storage words
    bwr(12'h010, 32'h1234_5678); bwr(12'h014, 32'h9ABC_DEF0);
    bwr(12'h020, 32'h0F0F_00FF); bwr(12'h024, 32'hCAFE_0001);
    rd(12'h010, d); chk("R12 enable lo", d, 32'h1234_5678);
    rd(12'h014, d); chk("R12 enable hi", d, 32'h9ABC_DEF0);
    rd(12'h020, d); chk("R12 polarity lo", d, 32'h0F0F_00FF);
    rd(12'h024, d); chk("R12 polarity hi", d, 32'hCAFE_0001);
    cmp("R12");
    // unmask with nothing pending
    cyc('0, '0, 1'b1, 32'h0, 1'b0, 32'h0);
    cmp("R5 empty unmask");
    rd(12'h00C, d); chk("R5 mask hi kept", d, 32'hFFFF_FFFF);
    // R2 R3 R4 sweep over all pending patterns
    for (int p = 0; p < 256; p++) begin
      cyc('0, '0, 1'b0, 32'h0, 1'b1, 32'h0);
      pend = 8'(p);
      cyc(8'hFF, '0, 1'b0, 32'h0, 1'b0, 32'h0);
      cmp("R2 R4 assert");
      cyc(8'hFF, '0, 1'b0, 32'h0, 1'b0, 32'h0);
      cmp("R2 second assert");
      cyc('0, 8'hFF, 1'b0, 32'h0, 1'b0, 32'h0);
      cmp("R3 R4 withdraw");
    end
    // R7 status load and masked readback
    cyc('0, '0, 1'b0, 32'h0, 1'b1, 32'hA5);
    rd(12'h018, d); chk("R7 status load", d, 32'hA5);
    // R5 R6 mask sweep with all pending
    pend = 8'hFF;
    for (int m = 0; m < 256; m++) begin
      cyc('0, '0, 1'b1, 32'(m), 1'b0, 32'h0);
      cmp("R5 R6 mask write");
    end
    // R10 same-cycle ordering: sources 0 and 5 share line 0
    cyc('0, '0, 1'b1, 32'h0, 1'b0, 32'h0);
    cyc('0, '0, 1'b0, 32'h0, 1'b1, 32'h20);
    pend = 8'h01;
    cyc(8'h01, 8'h20, 1'b0, 32'h0, 1'b0, 32'h0);
    chk("R10 shared line high", 32'(irq[0]), 32'h1);
    rd(12'h018, d); chk("R10 status", d, 32'h01);
    cmp("R10");
    // R11 out-of-range vector (source 3 -> 4) and hold
    cyc('0, '0, 1'b0, 32'h0, 1'b1, 32'h0);
    pend = 8'h08;
    d = 32'(irq);
    cyc(8'h08, '0, 1'b0, 32'h0, 1'b0, 32'h0);
    chk("R11 no line driven", 32'(irq), d);
    rd(12'h018, d); chk("R11 status set", d, 32'h08);
    d = 32'(irq);
    repeat (5) @(posedge clk);
    #1 chk("R11 idle hold", 32'(irq), d);
    finished = 1;
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end
endmodule